// File: doc/BRIEF.md
# Fractional Predivide Clock Generator

This block turns one of three source clocks into a slower train of clock-enable pulses. Each source is presented as a one-cycle tick strobe in the block's clock domain. The strobe for the crystal input, the one for the first PLL and the one for the second PLL each mark one edge of that source. The selected ticks go through two stages. The first is a predivider that divides by 2, 2.5 or 3. The second is an integer divider that divides by 1 to 127. The block emits one single-cycle pulse on `clk_en_out` per divided period, and this pulse can gate a downstream divided clock.

All settings live in one 32-bit control register. It is written through a plain write strobe and is always visible on a read-back bus. The control word holds the enable bit, the source select, the predivider code and the integer divider. The ratio 2.5 comes from predivider steps that alternate between 3 and 2 source ticks. A new predivider code or integer divider is applied only when an output pulse completes. A change of source, or any condition that stops the clock, clears both counters.

Top module: `frac_clkgen`

## Requirements
- R1: The control register resets to zero and drives `rd_data`. A write with `wr_en` high replaces all 32 bits, and the new value is visible one cycle later.
- R2: Bits 14:13 select the source. 01 picks `src_tick[1]` (first PLL), 11 picks `src_tick[2]` (second PLL), and 00 or 10 picks `src_tick[0]` (crystal). Ticks on unselected sources have no effect.
- R3: While bit 15 (enable) is 0, `clk_en_out` stays low.
- R4: While the active predivider code in bits 9:8 is 0, no pulse is produced.
- R5: Predivider codes 1, 2 and 3 make one predivider step every 2, 2.5 and 3 selected ticks, that is every (code+3)/2 ticks. Code 2 alternates steps of 3 and 2 ticks, starting with 3 after a restart.
- R6: Bits 6:0 set the integer divider. A value N from 1 to 127 gives one output pulse per N predivider steps, so one pulse per (code+3)·N/2 ticks on average. A value of 0 produces no pulse.
- R7: Bit 7 is reserved. It reads back as written and never changes the pulse train.
- R8: A new predivider code or integer divider written while running is applied only when the next output pulse completes. The period in progress keeps the old setting.
- R9: A change of the decoded source clears both counters and drops the tick in that cycle. The first pulse afterwards comes one full divided period of the new source later.
- R10: Each output pulse lasts one cycle. It is registered on the clock edge after the selected tick that completes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all source ticks are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control register contents |
| src_tick | input | 3 | Source tick strobes: [0] crystal, [1] first PLL, [2] second PLL |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
The tick strobes are driven in three patterns. With every source ticking each cycle, output gaps equal tick counts exactly, so the 2, 2.5 and 3 predivider ratios and the 1 and 127 integer limits can be measured directly. With only the second PLL ticking, the select decode is isolated: a wrong mapping of 11 or 10 shows up as a pulse train that is present or missing. With pseudo-random ticks on all three sources, each decoded select sees a different stream, so routing errors, alternation-phase errors and mistimed reloads surface as cycle mismatches against the behavioural model. Mid-period writes, source switches and toggles of the reserved bit are applied under these patterns to separate boundary-aligned updates from immediate ones.

// File: rtl/fpcg_pkg.sv
package fpcg_pkg;
    // control word layout: these positions are decoded by hardware
    localparam int CTRL_W   = 32;
    localparam int DIV_W    = 7;
    localparam int PRE_W    = 2;
    localparam int NSRC     = 3;
    localparam int DIV_LSB  = 0;
    localparam int PRE_LSB  = 8;
    localparam int SEL_LSB  = 13;
    localparam int EN_BIT   = 15;

    typedef enum logic [1:0] {
        SRC_XTAL  = 2'd0,
        SRC_PLL_A = 2'd1,
        SRC_PLL_B = 2'd2
    } src_e;

    // 01 -> first PLL, 11 -> second PLL, anything else -> crystal
    function automatic src_e pick_src(input logic [1:0] fld);
        case (fld)
            2'b01:   return SRC_PLL_A;
            2'b11:   return SRC_PLL_B;
            default: return SRC_XTAL;
        endcase
    endfunction
endpackage

// File: rtl/fpcg_prediv.sv
// Fractional predivider: one step per (code+3)/2 ticks, odd ratios
// alternating long/short so the average is exact.
module fpcg_prediv #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [PRE_W-1:0] code,
    output logic             step
);
    localparam int HW = PRE_W + 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          alt;
    } pd_s;

    pd_s           st_q, st_d;
    logic [HW-1:0] half_d;
    logic [HW-1:0] len_d;
    logic [HW-1:0] inc_d;

    always_comb begin
        half_d = HW'(code) + HW'(3);
        len_d  = (half_d >> 1) + HW'(half_d[0] & ~st_q.alt);
        inc_d  = st_q.cnt + HW'(1);
        step   = tick && (inc_d == len_d);
        st_d   = st_q;
        if (clr) begin
            st_d = '0;
        end else if (tick) begin
            if (step) begin
                st_d.cnt = '0;
                st_d.alt = half_d[0] ? ~st_q.alt : 1'b0;
            end else begin
                st_d.cnt = inc_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fpcg_intdiv.sv
// Integer stage: done on the step that reaches the limit.
module fpcg_intdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DIV_W-1:0] limit,
    output logic             done
);
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W:0]   inc_d;

    always_comb begin
        inc_d = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
        done  = step && (inc_d == {1'b0, limit});
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (done) cnt_d = '0;
        else if (step) cnt_d = inc_d[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
    import fpcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic [NSRC-1:0]   src_tick,
    output logic              clk_en_out
);
    localparam int PRE_HI = PRE_LSB + PRE_W - 1;
    localparam int DIV_HI = DIV_LSB + DIV_W - 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [PRE_W-1:0]  pre;
        logic [DIV_W-1:0]  div;
        src_e              sel;
        logic              out;
    } top_s;

    top_s             r_q, r_d;
    src_e             sel_now;
    logic             run;
    logic             restart;
    logic             tick_g;
    logic             pre_step;
    logic             pre_clr;
    logic             done;
    logic [PRE_W-1:0] f_pre;
    logic [DIV_W-1:0] f_div;

    always_comb begin
        sel_now = pick_src(r_q.ctrl[SEL_LSB+1:SEL_LSB]);
        f_pre   = r_q.ctrl[PRE_HI:PRE_LSB];
        f_div   = r_q.ctrl[DIV_HI:DIV_LSB];
        run     = r_q.ctrl[EN_BIT] && (r_q.pre != '0) && (r_q.div != '0);
        restart = !run || (sel_now != r_q.sel);
        tick_g  = src_tick[sel_now] && !restart;
        pre_clr = restart || (done && (f_pre != r_q.pre));
    end

    fpcg_prediv #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .tick  (tick_g),
        .code  (r_q.pre),
        .step  (pre_step)
    );

    fpcg_intdiv #(.DIV_W(DIV_W)) u_int (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .step  (pre_step),
        .limit (r_q.div),
        .done  (done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ctrl = wr_en ? wr_data : r_q.ctrl;
        r_d.out  = done;
        if (restart) begin
            r_d.pre = f_pre;
            r_d.div = f_div;
            r_d.sel = sel_now;
        end else if (done) begin
            // settings switch only on a completed period
            r_d.pre = f_pre;
            r_d.div = f_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{ctrl: '0, pre: '0, div: '0, sel: SRC_XTAL, out: 1'b0};
        else        r_q <= r_d;
    end

    assign rd_data    = r_q.ctrl;
    assign clk_en_out = r_q.out;
endmodule

module fpcg_chk
    import fpcg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] rd_data,
    input logic [NSRC-1:0]   src_tick,
    input logic              clk_en_out
);
    // R1
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> rd_data == $past(wr_data));

    // R2
    src_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> $past(src_tick[pick_src(rd_data[SEL_LSB+1:SEL_LSB])]));

    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_BIT] |=> !clk_en_out);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |=> !clk_en_out);
endmodule

bind frac_clkgen fpcg_chk u_chk (.*);

// File: tb/sim_frac_clkgen.sv
`timescale 1ns/1ps
module sim_frac_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  src_tick = '0;
    logic        clk_en_out;

    int n_chk = 0;
    int n_fail = 0;
    int tmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    frac_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .src_tick(src_tick), .clk_en_out(clk_en_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input logic [1:0] sel,
                                       input int pre, input int dv, input bit rsv);
        return {16'h0, en, sel, 3'b000, 2'(pre), rsv, 7'(dv)};
    endfunction

    function automatic int dec(input logic [1:0] f);
        return (f == 2'b01) ? 1 : (f == 2'b11) ? 2 : 0;
    endfunction

    // tick pattern driver
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tmode)
            0:       src_tick = 3'b111;
            1:       src_tick = lfsr[2:0];
            default: src_tick = 3'b100;
        endcase
    end

    // behavioural reference: half-tick accumulator
    logic [31:0] m_ctrl;
    int m_pre, m_div, m_sel, m_acc, m_dc, s_now;
    bit m_exp;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_pre = 0; m_div = 0; m_sel = 0; m_acc = 0; m_dc = 0; m_exp = 0;
        end else begin
            s_now = dec(m_ctrl[14:13]);
            m_exp = 0;
            if (!m_ctrl[15] || m_pre == 0 || m_div == 0 || s_now != m_sel) begin
                m_acc = 0; m_dc = 0;
                m_pre = int'(m_ctrl[9:8]); m_div = int'(m_ctrl[6:0]); m_sel = s_now;
            end else if (src_tick[s_now]) begin
                m_acc += 2;
                if (m_acc >= m_pre + 3) begin
                    m_acc -= m_pre + 3;
                    m_dc++;
                    if (m_dc == m_div) begin
                        m_exp = 1; m_dc = 0;
                        if (int'(m_ctrl[9:8]) != m_pre) m_acc = 0;
                        m_pre = int'(m_ctrl[9:8]); m_div = int'(m_ctrl[6:0]);
                    end
                end
            end
            if (wr_en) m_ctrl = wr_data;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(clk_en_out == m_exp, "R10 model", longint'(clk_en_out), longint'(m_exp));
            chk(rd_data == m_ctrl, "R1 model", longint'(rd_data), longint'(m_ctrl));
        end
    end

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse();
        while (!clk_en_out) @(negedge clk);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_en_out);
    endtask

    task automatic count_pulses(input int cyc, output int n);
        n = 0;
        repeat (cyc) begin @(negedge clk); if (clk_en_out) n++; end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        summary();
    end

    initial begin
        int g, g2, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1 reset state
        chk(rd_data == 32'h0, "R1 reset", longint'(rd_data), 0);
        chk(clk_en_out == 1'b0, "R1 reset out", longint'(clk_en_out), 0);
        // R1 full readback, R3 enable clear
        wr(32'hA5A5_2AFF);
        chk(rd_data == 32'hA5A5_2AFF, "R1 readback", longint'(rd_data), 32'hA5A5_2AFF);
        count_pulses(40, n);
        chk(n == 0, "R3 disabled", n, 0);
        // R4 predivider code 0
        wr(cw(1, 2'b00, 0, 3, 0));
        count_pulses(40, n);
        chk(n == 0, "R4 code zero", n, 0);
        // R6 integer divider 0
        wr(cw(1, 2'b00, 1, 0, 0));
        count_pulses(40, n);
        chk(n == 0, "R6 div zero", n, 0);
        // R5 ratios with ticks every cycle
        wr(cw(1, 2'b00, 1, 1, 0));
        wait_pulse(); gap(g);
        chk(g == 2, "R5 div2", g, 2);
        wr(cw(1, 2'b00, 3, 1, 0));
        wait_pulse(); gap(g); gap(g);
        chk(g == 3, "R5 div3", g, 3);
        wr(cw(1, 2'b00, 2, 1, 0));
        wait_pulse(); gap(g); gap(g); gap(g2);
        chk(g + g2 == 5, "R5 div2.5 pair", g + g2, 5);
        chk(g != g2, "R5 alternation", g, 5 - g2);
        wr(cw(1, 2'b00, 2, 2, 0));
        wait_pulse(); gap(g); gap(g);
        chk(g == 5, "R5 R6 div5", g, 5);
        // R6 extremes
        wr(cw(1, 2'b00, 1, 127, 0));
        wait_pulse(); gap(g); gap(g);
        chk(g == 254, "R6 div127", g, 254);
        // R7 reserved bit set and toggled
        wr(cw(1, 2'b00, 1, 3, 1));
        wait_pulse(); gap(g); gap(g);
        chk(g == 6, "R7 rsv set", g, 6);
        chk(rd_data[7] == 1'b1, "R7 readback", longint'(rd_data[7]), 1);
        wr(cw(1, 2'b00, 1, 3, 0));
        n = 1; while (!clk_en_out) begin @(negedge clk); n++; end
        gap(g);
        chk(g == 6, "R7 rsv toggled", g, 6);
        // R8 mid-period change
        wr(cw(1, 2'b00, 1, 4, 0));
        wait_pulse(); gap(g);
        chk(g == 8, "R8 base", g, 8);
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        wr(cw(1, 2'b00, 1, 2, 0)); n++;
        while (!clk_en_out) begin @(negedge clk); n++; end
        chk(n == 8, "R8 old period kept", n, 8);
        gap(g);
        chk(g == 4, "R8 new period", g, 4);
        // R9 source switch restarts
        wr(cw(1, 2'b00, 1, 3, 0));
        wait_pulse(); gap(g);
        wr(cw(1, 2'b01, 1, 3, 0));
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_en_out);
        chk(n == 7, "R9 restart delay", n, 7);
        // R2 decode with only the second PLL ticking
        tmode = 2;
        wr(cw(1, 2'b11, 1, 2, 0));
        count_pulses(60, n);
        chk(n >= 13, "R2 sel11 pll2", n, 14);
        wr(cw(1, 2'b10, 1, 2, 0));
        count_pulses(60, n);
        chk(n == 0, "R2 sel10 xtal", n, 0);
        wr(cw(1, 2'b01, 1, 2, 0));
        count_pulses(60, n);
        chk(n == 0, "R2 sel01 pll1", n, 0);
        // random ticks, model comparison through mixed changes
        tmode = 1;
        for (int k = 0; k < 24; k++) begin
            wr(cw(1, 2'(k % 4), 1 + (k % 3), 1 + (k * 5) % 9, k[0]));
            repeat (40 + (k % 7) * 5) @(negedge clk);
        end
        wr(cw(0, 2'b01, 2, 3, 0));
        repeat (20) @(negedge clk);
        summary();
    end
endmodule